// File: doc/BRIEF.md
# IR Pulse-Width Capture Engine

This block watches the demodulated output of an infrared receiver and turns each stretch of constant level into a byte. The byte holds the length of that stretch in sample ticks. A message is stored as alternating mark and gap bytes, with a mark first, in a flop-based bank of 68 bytes. Software reads the bank as 17 consecutive 32-bit words over a simple word-addressed register bus.

The input goes through a two-flop synchronizer and then a programmable de-glitch filter. Tick timing comes from a programmable divider of the reference clock. Capture ends in one of two ways:
- A gap lasts longer than a programmable multiple of 256 ticks. The gap is stored as a zero byte.
- The bank fills up.

In both cases a pending flag is set. The interrupt line shows that flag while the interrupt enable is set. Software acknowledges the flag with a clear write, and a restart write zeroes the bank and re-arms capture.

Top module: `ir_pw_capture`

## Requirements
- R1: Once armed, each change of the filtered level stores the length of the level just ended, in ticks, as one byte. Bytes alternate mark then gap, and byte 0 is a mark (input high).
- R2: A mark or gap of more than 255 ticks is stored as 8'hFF.
- R3: A gap reaching M×256 ticks ends capture and stores 8'h00 in its slot. M is the value of CFG bits 22:16, with 0 treated as 1. All later bytes stay zero, the pending flag is set, and later input activity changes nothing until restart.
- R4: Byte k is read at word address 0x20 + k/4, in bits 8×(k mod 4)+7 : 8×(k mod 4). The bank occupies word addresses 0x20 to 0x30.
- R5: When byte 67 is stored, the pending flag is set at once. Edges after that are discarded and leave the bank unchanged.
- R6: Capture runs only while both bit 0 (capture enable) and bit 13 (width detection enable) of CFG (address 0x00) are set. Otherwise input activity leaves the bank unchanged.
- R7: Writing 1 to bit 0 of address 0x03 zeroes all 68 bytes and returns the engine to waiting for a mark.
- R8: The interrupt output equals the pending flag ANDed with bit 0 of address 0x04. Writing 1 to bit 0 of address 0x05 clears the pending flag.
- R9: The filtered level takes a new value only after the synchronized input has differed from it for D consecutive clocks. D is the value of bits 12:8 of address 0x02, with 0 treated as 1. Shorter glitches are dropped.
- R10: One tick occurs every P+1 clocks, where P is the value of bits 15:0 of address 0x01.
- R11: After restart, capture begins only on the first high filtered level. A leading low level is not recorded.
- R12: After reset all configuration fields, the bank and the pending flag are zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated IR level, high = mark |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several rules on every cycle:
- The filter keeps its level whenever the synchronized input agrees with it.
- Ticks are spaced by the programmed period.
- Bytes are written only while capturing.
- A finished capture stays frozen until restart.
- The entry index never passes the bank.
- A restart empties the bank.
- An acknowledge drops the interrupt.

Only the bench scenarios can show the actual stored widths. That covers saturation, the zero terminator, byte packing order, rejection of glitches, tick scaling, the enable gating and the discard after a full bank, all of which depend on whole stimulus sequences.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CFG     = 6'h00;
  localparam logic [ADDR_W-1:0] A_PERIOD  = 6'h01;
  localparam logic [ADDR_W-1:0] A_FILTER  = 6'h02;
  localparam logic [ADDR_W-1:0] A_RESTART = 6'h03;
  localparam logic [ADDR_W-1:0] A_IRQEN   = 6'h04;
  localparam logic [ADDR_W-1:0] A_IRQCLR  = 6'h05;
  localparam logic [ADDR_W-1:0] A_BANK    = 6'h20;

  localparam int CFG_CAP_BIT = 0;
  localparam int CFG_PWD_BIT = 13;
  localparam int CFG_EOM_LSB = 16;
  localparam int FLT_DG_LSB  = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } cap_state_e;
endpackage

// File: rtl/ir_sync_filter.sv
module ir_sync_filter #(
  parameter int DG_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic [DG_W-1:0] dg_need,
  output logic            level
);
  logic            s1_q, s2_q;
  logic            lvl_q, lvl_d;
  logic [DG_W-1:0] run_q, run_d;
  logic [DG_W:0]   need_eff;
  logic [DG_W:0]   run_nxt;

  always_comb begin
    need_eff = (dg_need == '0) ? (DG_W+1)'(1) : {1'b0, dg_need};
    run_nxt  = {1'b0, run_q} + (DG_W+1)'(1);
    lvl_d    = lvl_q;
    run_d    = '0;
    if (s2_q != lvl_q) begin
      if (run_nxt >= need_eff) begin
        lvl_d = s2_q;
      end else begin
        run_d = run_nxt[DG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      s1_q  <= din;
      s2_q  <= s1_q;
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

  assign level = lvl_q;

  // R9: agreement between synchronized input and filtered level keeps the level
  p_hold_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q == lvl_q) |=> $stable(lvl_q));
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] period,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= period);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: with a nonzero period two ticks are never adjacent
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period != '0) |=> (!tick || period == '0));
endmodule

// File: rtl/ir_width_fsm.sv
module ir_width_fsm
  import ir_cap_pkg::*;
#(
  parameter int ENTRIES = 68,
  parameter int IDX_W   = 7,
  parameter int EOM_W   = 7,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             tick,
  input  logic             enable,
  input  logic             restart,
  input  logic [EOM_W-1:0] eom_mult,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_byte,
  output logic             done_evt
);
  cap_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q;
  logic [EOM_W-1:0] eom_eff;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] cnt_start, cnt_inc;
  logic [7:0]       sat_byte;

  always_comb begin
    eom_eff   = (eom_mult == '0) ? EOM_W'(1) : eom_mult;
    thr       = CNT_W'({eom_eff, 8'h00});
    cnt_start = CNT_W'(tick);
    cnt_inc   = (tick && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;
    sat_byte  = (cnt_q > CNT_W'(255)) ? 8'hFF : cnt_q[7:0];

    state_d  = state_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    wr_en    = 1'b0;
    wr_byte  = 8'h00;
    done_evt = 1'b0;

    if (restart) begin
      state_d = ST_IDLE;
      idx_d   = '0;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (enable && level) begin
            state_d = ST_RUN;
            cnt_d   = cnt_start;
          end
        end
        ST_RUN: begin
          if (enable) begin
            if (level != lvl_q) begin
              wr_en   = 1'b1;
              wr_byte = sat_byte;
              cnt_d   = cnt_start;
              if (idx_q == IDX_W'(ENTRIES-1)) begin
                state_d  = ST_DONE;
                done_evt = 1'b1;
              end else begin
                idx_d = idx_q + 1'b1;
              end
            end else if (!level && cnt_q >= thr) begin
              wr_en    = 1'b1;
              wr_byte  = 8'h00;
              state_d  = ST_DONE;
              done_evt = 1'b1;
            end else begin
              cnt_d = cnt_inc;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      lvl_q   <= level;
    end
  end

  assign wr_idx = idx_q;

  // R1: entries are written only while a message is being captured
  p_write_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state_q == ST_RUN));

  // R3: a finished capture stays frozen until restart
  p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !restart) |=> (state_q == ST_DONE && !wr_en));

  // R5: the write index never runs past the bank
  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(ENTRIES));
endmodule

// File: rtl/ir_capture_bank.sv
module ir_capture_bank #(
  parameter int N_WORDS = 17,
  parameter int IDX_W   = 7,
  parameter int SEL_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [31:0]      rd_data
);
  localparam int ENTRIES = 4 * N_WORDS;

  logic [ENTRIES-1:0][7:0] bytes;
  logic [N_WORDS-1:0][31:0] words;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [7:0] ent_q;
    logic       hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q <= 8'h00;
      else if (clear) ent_q <= 8'h00;
      else if (hit)   ent_q <= wr_byte;
    end
    assign bytes[e] = ent_q;
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign words[w] = {bytes[4*w+3], bytes[4*w+2], bytes[4*w+1], bytes[4*w]};
  end

  always_comb begin
    rd_data = 32'h0;
    if (rd_sel < SEL_W'(N_WORDS)) rd_data = words[rd_sel];
  end

  // R7: restart empties every entry
  p_clear_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (bytes == '0));
endmodule

// File: rtl/ir_pw_capture.sv
module ir_pw_capture
  import ir_cap_pkg::*;
#(
  parameter int N_WORDS = 17,
  parameter int DIV_W   = 16,
  parameter int DG_W    = 5,
  parameter int EOM_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int ENTRIES = 4 * N_WORDS;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int SEL_W   = $clog2(N_WORDS);
  localparam int CNT_W   = EOM_W + 9;

  logic             cap_en_q, cap_en_d;
  logic             pwd_en_q, pwd_en_d;
  logic [EOM_W-1:0] eom_q, eom_d;
  logic [DIV_W-1:0] period_q, period_d;
  logic [DG_W-1:0]  dg_q, dg_d;
  logic             irq_en_q, irq_en_d;
  logic             pend_q, pend_d;

  logic             restart, ack;
  logic             level, tick;
  logic             wr_en, done_evt;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_byte;
  logic [ADDR_W-1:0] bank_off;
  logic [31:0]      bank_data;
  logic             in_bank;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    restart  = bus_wr && bus_addr == A_RESTART && bus_wdata[0];
    ack      = bus_wr && bus_addr == A_IRQCLR  && bus_wdata[0];
    cap_en_d = cap_en_q;
    pwd_en_d = pwd_en_q;
    eom_d    = eom_q;
    period_d = period_q;
    dg_d     = dg_q;
    irq_en_d = irq_en_q;
    if (bus_wr) begin
      case (bus_addr)
        A_CFG: begin
          cap_en_d = bus_wdata[CFG_CAP_BIT];
          pwd_en_d = bus_wdata[CFG_PWD_BIT];
          eom_d    = bus_wdata[CFG_EOM_LSB +: EOM_W];
        end
        A_PERIOD: period_d = bus_wdata[DIV_W-1:0];
        A_FILTER: dg_d     = bus_wdata[FLT_DG_LSB +: DG_W];
        A_IRQEN:  irq_en_d = bus_wdata[0];
        default: ;
      endcase
    end
    if (done_evt)  pend_d = 1'b1;
    else if (ack)  pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en_q <= 1'b0;
      pwd_en_q <= 1'b0;
      eom_q    <= '0;
      period_q <= '0;
      dg_q     <= '0;
      irq_en_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      cap_en_q <= cap_en_d;
      pwd_en_q <= pwd_en_d;
      eom_q    <= eom_d;
      period_q <= period_d;
      dg_q     <= dg_d;
      irq_en_q <= irq_en_d;
      pend_q   <= pend_d;
    end
  end

  assign irq = pend_q & irq_en_q;

  ir_sync_filter #(.DG_W(DG_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .din(ir_in), .dg_need(dg_q), .level(level)
  );

  ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .period(period_q), .tick(tick)
  );

  ir_width_fsm #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .EOM_W(EOM_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .level(level), .tick(tick),
    .enable(cap_en_q & pwd_en_q), .restart(restart), .eom_mult(eom_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .done_evt(done_evt)
  );

  assign bank_off = bus_addr - A_BANK;
  assign in_bank  = (bus_addr >= A_BANK) && (bank_off < ADDR_W'(N_WORDS));

  ir_capture_bank #(.N_WORDS(N_WORDS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clear(restart), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .rd_sel(bank_off[SEL_W-1:0]), .rd_data(bank_data)
  );

  always_comb begin
    bus_rdata = 32'h0;
    if (in_bank) begin
      bus_rdata = bank_data;
    end else begin
      case (bus_addr)
        A_CFG: begin
          bus_rdata[CFG_CAP_BIT]            = cap_en_q;
          bus_rdata[CFG_PWD_BIT]            = pwd_en_q;
          bus_rdata[CFG_EOM_LSB +: EOM_W]   = eom_q;
        end
        A_PERIOD: bus_rdata[DIV_W-1:0]       = period_q;
        A_FILTER: bus_rdata[FLT_DG_LSB +: DG_W] = dg_q;
        A_IRQEN:  bus_rdata[0]               = irq_en_q;
        default: ;
      endcase
    end
  end

  // R8: an acknowledge with no new completion drops the interrupt
  p_irq_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done_evt) |=> !irq);

  // R3: a completion with the enable held raises the interrupt
  p_irq_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && irq_en_q && !(bus_wr && bus_addr == A_IRQEN)) |=> irq);
endmodule

// File: tb/test_ir_pw_capture.sv
module test_ir_pw_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_in;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  always #10 clk = ~clk;

  ir_pw_capture i_ir_pw_capture (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  // monitor: pops expectations and compares mid high phase
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {31'b0, irq} : bus_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // caller sits at a falling edge
  task automatic drive(input logic lv, input int n);
    ir_in = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; ir_in = 1'b0; bus_wr = 1'b0; bus_addr = 6'h0; bus_wdata = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    expect_irq(1'b0, "R12 irq after reset");
    expect_rd(6'h00, 32'h0, "R12 config after reset");
    expect_rd(6'h20, 32'h0, "R12 bank after reset");

    bus_write(6'h02, 32'h0000_0100);
    bus_write(6'h01, 32'h0);
    // R6 capture enable alone is not enough
    bus_write(6'h00, 32'h0001_0001);
    drive(1, 10); drive(0, 10); drive(1, 10); drive(0, 20);
    expect_rd(6'h20, 32'h0, "R6 no capture without width enable");

    // full enable, eom multiple 1
    bus_write(6'h00, 32'h0001_2001);
    drive(0, 50);            // R11 leading low not recorded
    drive(1, 10); drive(0, 20); drive(1, 300); drive(0, 40); drive(1, 5); drive(0, 400);
    expect_irq(1'b0, "R8 irq gated while enable low");
    bus_write(6'h04, 32'h1);
    expect_irq(1'b1, "R3 irq after end-of-message gap");
    expect_rd(6'h20, 32'h28FF_140A, "R1 R2 R4 R11 word0 widths");
    expect_rd(6'h21, 32'h0000_0005, "R3 zero terminator");
    expect_rd(6'h22, 32'h0, "R3 remaining entries zero");
    expect_rd(6'h30, 32'h0, "R4 R3 last word zero");
    drive(1, 20); drive(0, 20); drive(1, 20); drive(0, 20);
    expect_rd(6'h21, 32'h0000_0005, "R3 activity after end ignored");
    expect_rd(6'h22, 32'h0, "R3 no new entries after end");
    bus_write(6'h05, 32'h1);
    expect_irq(1'b0, "R8 acknowledge clears irq");
    bus_write(6'h03, 32'h1);
    expect_rd(6'h20, 32'h0, "R7 restart clears word0");
    expect_rd(6'h21, 32'h0, "R7 restart clears word1");

    // R9 de-glitch of 4 clocks
    bus_write(6'h02, 32'h0000_0400);
    drive(0, 10);
    drive(1, 14); drive(0, 2); drive(1, 14); drive(0, 30); drive(1, 8); drive(0, 400);
    expect_rd(6'h20, 32'h0008_1E1E, "R9 short glitch filtered");
    expect_irq(1'b1, "R9 message completes");
    bus_write(6'h05, 32'h1);
    bus_write(6'h03, 32'h1);

    // R10 divider: one tick per 4 clocks
    bus_write(6'h02, 32'h0000_0100);
    bus_write(6'h01, 32'h3);
    drive(0, 10);
    drive(1, 40); drive(0, 80); drive(1, 12); drive(0, 1200);
    expect_rd(6'h20, 32'h0003_140A, "R10 tick divider scaling");
    expect_irq(1'b1, "R10 scaled end-of-message");
    bus_write(6'h01, 32'h0);
    bus_write(6'h05, 32'h1);
    bus_write(6'h03, 32'h1);

    // R5 bank full
    drive(0, 10);
    for (int i = 0; i < 34; i++) begin
      drive(1, 3); drive(0, 3);
    end
    drive(1, 3); drive(0, 5);
    expect_irq(1'b1, "R5 irq when bank full");
    expect_rd(6'h20, 32'h0303_0303, "R5 first word");
    expect_rd(6'h30, 32'h0303_0303, "R5 last word");
    drive(1, 7); drive(0, 7); drive(1, 7); drive(0, 7);
    expect_rd(6'h30, 32'h0303_0303, "R5 edges after full discarded");
    expect_rd(6'h20, 32'h0303_0303, "R5 first word unchanged");

    finished = 1;
    report();
  end
endmodule